// File: doc/BRIEF.md
# Circular Return Address Stack

This block supplies predicted return targets to an instruction fetch unit. Whenever fetch recognises a call, it raises the call strobe together with the call's program counter. The block then records the address of the instruction that follows the call, which is the call address aligned to four bytes plus four. Whenever fetch recognises a return, it raises the return strobe. In that cycle the block's output already shows the most recent recorded address, which fetch can use as the predicted target, and the entry is removed at the clock edge. All updates happen speculatively at fetch time. Nothing waits for the call or the return to resolve.

Storage is a ring of twelve entries that never refuses an operation. If a thirteenth call arrives, its address silently replaces the oldest entry. A return on an empty stack still moves the ring pointer backwards, and the output then shows whatever stale address occupies that slot. A separate saturating occupancy count, held between zero and twelve, drives the valid flag, so fetch can tell when a prediction is backed by a recorded call. When a call and a return arrive in the same cycle, the pop is applied first and the push second. The pointer therefore stays where it is and the top entry is overwritten.

Top module: `ras_ring_predictor`

## Requirements
- R1: While reset is held, and after it is released, pred_valid_o is 0 and pred_target_o is 0. Reset clears every entry to 0.
- R2: A cycle with call_i=1 and ret_i=0 records the link address ({call_pc_i[63:2],2'b00} + 4, modulo 2^64). From the first cycle after that clock edge, pred_target_o shows this address and pred_valid_o is 1.
- R3: A cycle with ret_i=1 and call_i=0 removes the top entry. After the edge, pred_target_o shows the next older entry, so targets come back in last-in, first-out order.
- R4: The occupancy count stays within 0 and 12 and saturates at both ends. pred_valid_o is 1 exactly when the count is nonzero. After 13 calls, 11 returns leave pred_valid_o at 1 and the 12th return drives it to 0.
- R5: A call made while 12 entries are held overwrites the oldest entry. The ring keeps the 12 most recent link addresses.
- R6: A return made while empty leaves pred_valid_o at 0 and still moves the pointer back one slot with wrap. pred_target_o then shows the stale content of that slot, and the next call writes into the slot just above it.
- R7: A cycle with call_i=1 and ret_i=1 replaces the top entry with the new link address and leaves the pointer unchanged. The count stays the same, except that it becomes 1 if it was 0.
- R8: call_pc_i[1:0] has no effect on the recorded address, and pred_target_o[1:0] is always 0.
- R9: A cycle with call_i=0 and ret_i=0 leaves pred_target_o and pred_valid_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Fetch has detected a call this cycle |
| call_pc_i | input | 64 | Address of the detected call |
| ret_i | input | 1 | Fetch has detected a return this cycle |
| pred_target_o | output | 64 | Predicted return target: the current top entry |
| pred_valid_o | output | 1 | High while the occupancy count is nonzero |

## Verification
Both outputs are decoded combinationally from registered state. So the prediction used by a return is the value present in the same cycle as the strobe, and the effect of a call, a return or both appears one clock edge later. The bench drives each operation on a falling edge and lets exactly one rising edge pass. It then compares pred_target_o and pred_valid_o at the next falling edge, which is where the updated state is first visible and well away from the active edge. Long scenarios, such as thirteen pushes followed by repeated pops, check after every single operation. This pins down both the order of the returned targets and the cycle in which pred_valid_o falls.

// File: rtl/ras_pkg.sv
package ras_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2,
      OP_SWAP = 2'd3
   } ras_op_e;

   function automatic ras_op_e ras_decode(input logic call, input logic ret);
      ras_op_e op;
      unique case ({call, ret})
         2'b10:   op = OP_PUSH;
         2'b01:   op = OP_POP;
         2'b11:   op = OP_SWAP;
         default: op = OP_IDLE;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/ras_link_calc.sv
module ras_link_calc #(
   parameter int ADDR_W     = 64,
   parameter int ALIGN_BITS = 2,
   parameter int INSN_BYTES = 4
) (
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] link_o
);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);
   localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(INSN_BYTES);

   always_comb begin
      link_o = (pc_i & ~LOW_MASK) + STEP;
   end
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
   import ras_pkg::*;
#(
   parameter int DEPTH = 12,
   parameter int PTR_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ras_op_e          op_i,
   output logic [PTR_W-1:0] tos_o,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_idx_o,
   output logic [CNT_W-1:0] occ_o
);
   localparam bit               POW2     = (DEPTH == (1 << PTR_W));
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [PTR_W-1:0] tos_q, tos_d, tos_up, tos_dn;
   logic [CNT_W-1:0] occ_q, occ_d;

   generate
      if (POW2) begin : g_wrap_free
         always_comb begin
            tos_up = tos_q + 1'b1;
            tos_dn = tos_q - 1'b1;
         end
      end else begin : g_wrap_cmp
         always_comb begin
            tos_up = (tos_q == LAST_IDX) ? '0 : tos_q + 1'b1;
            tos_dn = (tos_q == '0) ? LAST_IDX : tos_q - 1'b1;
         end
      end
   endgenerate

   always_comb begin
      tos_d    = tos_q;
      occ_d    = occ_q;
      wr_en_o  = 1'b0;
      wr_idx_o = tos_q;
      unique case (op_i)
         OP_PUSH: begin
            tos_d    = tos_up;
            wr_en_o  = 1'b1;
            wr_idx_o = tos_up;
            occ_d    = (occ_q == FULL_CNT) ? FULL_CNT : occ_q + 1'b1;
         end
         OP_POP: begin
            tos_d = tos_dn;
            occ_d = (occ_q == '0) ? '0 : occ_q - 1'b1;
         end
         OP_SWAP: begin
            wr_en_o  = 1'b1;
            wr_idx_o = tos_q;
            occ_d    = (occ_q == '0) ? CNT_W'(1) : occ_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tos_q <= '0;
         occ_q <= '0;
      end else begin
         tos_q <= tos_d;
         occ_q <= occ_d;
      end
   end

   assign tos_o = tos_q;
   assign occ_o = occ_q;
endmodule

// File: rtl/ras_storage.sv
module ras_storage #(
   parameter int DEPTH  = 12,
   parameter int ADDR_W = 64,
   parameter int PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_idx_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_idx_i,
   output logic [ADDR_W-1:0] rd_data_o
);
   logic [ADDR_W-1:0] slot_q [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n) begin
            slot_q[i] <= '0;
         end else if (wr_en_i && (wr_idx_i == PTR_W'(i))) begin
            slot_q[i] <= wr_data_i;
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx_i == PTR_W'(i)) rd_data_o = slot_q[i];
      end
   end
endmodule

// File: rtl/ras_ring_predictor.sv
module ras_ring_predictor
   import ras_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int DEPTH      = 12,
   parameter int ALIGN_BITS = 2,
   parameter int INSN_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic [ADDR_W-1:0] call_pc_i,
   input  logic              ret_i,
   output logic [ADDR_W-1:0] pred_target_o,
   output logic              pred_valid_o
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ras_ring_predictor: DEPTH must be at least 2");
      end
      if (ALIGN_BITS >= ADDR_W) begin : g_bad_align
         $error("ras_ring_predictor: ALIGN_BITS must be below ADDR_W");
      end
      if ((INSN_BYTES % (1 << ALIGN_BITS)) != 0) begin : g_bad_step
         $error("ras_ring_predictor: INSN_BYTES must keep alignment");
      end
   endgenerate

   ras_op_e           op;
   logic [ADDR_W-1:0] link;
   logic [PTR_W-1:0]  tos;
   logic              wr_en;
   logic [PTR_W-1:0]  wr_idx;
   logic [CNT_W-1:0]  occ_q;

   assign op = ras_decode(call_i, ret_i);

   ras_link_calc #(
      .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .INSN_BYTES(INSN_BYTES)
   ) u_link (
      .pc_i   (call_pc_i),
      .link_o (link)
   );

   ras_ptr_ctrl #(
      .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op),
      .tos_o    (tos),
      .wr_en_o  (wr_en),
      .wr_idx_o (wr_idx),
      .occ_o    (occ_q)
   );

   ras_storage #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (link),
      .rd_idx_i  (tos),
      .rd_data_o (pred_target_o)
   );

   assign pred_valid_o = (occ_q != '0);
endmodule

// File: rtl/ras_ring_checker.sv
module ras_ring_checker #(
   parameter int ADDR_W     = 64,
   parameter int DEPTH      = 12,
   parameter int ALIGN_BITS = 2,
   parameter int INSN_BYTES = 4,
   parameter int CNT_W      = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              call_i,
   input logic [ADDR_W-1:0] call_pc_i,
   input logic              ret_i,
   input logic [ADDR_W-1:0] pred_target_o,
   input logic              pred_valid_o,
   input logic [CNT_W-1:0]  occ
);
   localparam logic [ADDR_W-1:0] CHK_MASK = ~ADDR_W'((1 << ALIGN_BITS) - 1);

   // R2 and R7: any call leaves its link address on top one edge later
   a_r2_push_link: assert property (@(posedge clk) disable iff (!rst_n)
      call_i |=> (pred_target_o == (($past(call_pc_i) & CHK_MASK) + ADDR_W'(INSN_BYTES))));

   a_r2_push_valid: assert property (@(posedge clk) disable iff (!rst_n)
      call_i |=> pred_valid_o);

   a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_target_o & ~CHK_MASK) == '0);

   a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

   a_r3_pop_occ: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && occ != '0) |=> (occ == $past(occ) - 1'b1));

   a_r6_empty_pop_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && !pred_valid_o) |=> !pred_valid_o);

   a_r7_swap_occ: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && ret_i && occ != '0) |=> $stable(occ));

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!call_i && !ret_i) |=> ($stable(pred_target_o) && $stable(pred_valid_o)));
endmodule

bind ras_ring_predictor ras_ring_checker #(
   .ADDR_W(ADDR_W), .DEPTH(DEPTH), .ALIGN_BITS(ALIGN_BITS),
   .INSN_BYTES(INSN_BYTES), .CNT_W(CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .call_i        (call_i),
   .call_pc_i     (call_pc_i),
   .ret_i         (ret_i),
   .pred_target_o (pred_target_o),
   .pred_valid_o  (pred_valid_o),
   .occ           (occ_q)
);

// File: tb/tb_ras_ring_predictor.sv
`timescale 1ns/1ps
module tb_ras_ring_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_i = 1'b0;
   logic [63:0] call_pc_i = '0;
   logic        ret_i = 1'b0;
   logic [63:0] pred_target_o;
   logic        pred_valid_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   ras_ring_predictor dut (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc_i(call_pc_i),
      .ret_i(ret_i), .pred_target_o(pred_target_o), .pred_valid_o(pred_valid_o)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive on a falling edge, one rising edge, return at the next falling edge
   task automatic step(input logic c, input logic [63:0] pc, input logic r);
      call_i = c; call_pc_i = pc; ret_i = r;
      @(posedge clk);
      @(negedge clk);
      call_i = 1'b0; ret_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step(1'b0, '0, 1'b0);
      step(1'b0, '0, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 valid after reset", 64'(pred_valid_o), 64'd0);
      chk("R1 target after reset", pred_target_o, 64'd0);
      step(1'b1, 64'h1234_5670, 1'b0);
      do_reset();
      chk("R1 valid cleared by reset", 64'(pred_valid_o), 64'd0);
      chk("R1 target cleared by reset", pred_target_o, 64'd0);
   endtask

   task automatic t_lifo();
      do_reset();
      step(1'b1, 64'h1000, 1'b0);
      chk("R2 first link", pred_target_o, 64'h1004);
      chk("R2 valid after call", 64'(pred_valid_o), 64'd1);
      step(1'b1, 64'h2000, 1'b0);
      chk("R2 second link", pred_target_o, 64'h2004);
      step(1'b1, 64'h3008, 1'b0);
      chk("R2 third link", pred_target_o, 64'h300C);
      step(1'b0, '0, 1'b1);
      chk("R3 pop shows second", pred_target_o, 64'h2004);
      step(1'b0, '0, 1'b1);
      chk("R3 pop shows first", pred_target_o, 64'h1004);
      chk("R3 valid with one left", 64'(pred_valid_o), 64'd1);
      step(1'b0, '0, 1'b1);
      chk("R4 valid low when drained", 64'(pred_valid_o), 64'd0);
   endtask

   function automatic logic [63:0] pc_of(input int k);
      return 64'h8000_0000_0000_0000 + 64'(k) * 64'd256;
   endfunction

   task automatic t_overflow_underflow();
      do_reset();
      for (int k = 0; k < 13; k++) begin
         step(1'b1, pc_of(k), 1'b0);
         chk("R5 push link", pred_target_o, pc_of(k) + 64'd4);
      end
      for (int j = 1; j <= 11; j++) begin
         step(1'b0, '0, 1'b1);
         chk("R5 pop order after wrap", pred_target_o, pc_of(12 - j) + 64'd4);
         chk("R4 valid while entries remain", 64'(pred_valid_o), 64'd1);
      end
      step(1'b0, '0, 1'b1);
      chk("R4 valid low after twelfth pop", 64'(pred_valid_o), 64'd0);
      chk("R5 oldest was overwritten", pred_target_o, pc_of(12) + 64'd4);
      step(1'b0, '0, 1'b1);
      chk("R6 empty pop keeps valid low", 64'(pred_valid_o), 64'd0);
      chk("R6 empty pop shows stale slot", pred_target_o, pc_of(11) + 64'd4);
      step(1'b1, 64'hABC0, 1'b0);
      chk("R6 push after underflow", pred_target_o, 64'hABC4);
      chk("R6 valid after push", 64'(pred_valid_o), 64'd1);
      step(1'b0, '0, 1'b1);
      chk("R6 pointer wrapped below", pred_target_o, pc_of(11) + 64'd4);
      chk("R6 valid low again", 64'(pred_valid_o), 64'd0);
   endtask

   task automatic t_simultaneous();
      do_reset();
      step(1'b1, 64'h100, 1'b0);
      step(1'b1, 64'h200, 1'b0);
      step(1'b1, 64'h300, 1'b1);
      chk("R7 top replaced", pred_target_o, 64'h304);
      step(1'b0, '0, 1'b1);
      chk("R7 entry below kept", pred_target_o, 64'h104);
      chk("R7 count unchanged", 64'(pred_valid_o), 64'd1);
      step(1'b0, '0, 1'b1);
      chk("R7 drained after two pops", 64'(pred_valid_o), 64'd0);
      do_reset();
      step(1'b1, 64'h500, 1'b1);
      chk("R7 swap on empty target", pred_target_o, 64'h504);
      chk("R7 swap on empty valid", 64'(pred_valid_o), 64'd1);
      step(1'b0, '0, 1'b1);
      chk("R7 swap on empty count one", 64'(pred_valid_o), 64'd0);
      chk("R7 stale slot below", pred_target_o, 64'd0);
   endtask

   task automatic t_align();
      do_reset();
      step(1'b1, 64'h0000_0000_0000_1003, 1'b0);
      chk("R8 low bits ignored", pred_target_o, 64'h1004);
      step(1'b1, 64'h0000_0000_0000_2001, 1'b0);
      chk("R8 low bits ignored odd", pred_target_o, 64'h2004);
      step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      chk("R2 link wraps at top of space", pred_target_o, 64'd0);
      chk("R2 valid on wrapped link", 64'(pred_valid_o), 64'd1);
   endtask

   task automatic t_idle();
      do_reset();
      step(1'b1, 64'h40, 1'b0);
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 64'hFFFF_0000, 1'b0);
         chk("R9 target held when idle", pred_target_o, 64'h44);
         chk("R9 valid held when idle", 64'(pred_valid_o), 64'd1);
      end
   endtask

   initial begin
      t_reset_state();
      t_lifo();
      t_overflow_underflow();
      t_simultaneous();
      t_align();
      t_idle();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule